// File: doc/BRIEF.md
# Fine-Grained Chunk Slot Allocator

This block places the missing 32-byte chunks of a 128-byte line into a cache set of sixteen chunk slots after a miss or a partial miss. The slots form four groups of four, and every group carries one shared tag. A request brings the set's valid bits, the four group shared tags, the shared and private tag of the line, and a mask of the chunks that are missing. One registered result comes back. It holds the slots to fill, the live slots to invalidate, the groups whose shared tag must be rewritten, and the slot given to each missing chunk. All of these are worked out in a single cycle.

Free slots are taken first, in a fixed order of preference. Invalid slots in a group that already holds the request's shared tag come first, then slots of groups with no valid chunk. When these are not enough, live chunks are evicted. Victims are chosen by a not-recently-used bit per slot, and a rotating start point taken from a free-running LFSR breaks ties. The block keeps those bits for every set. Accesses set the bits, and a set whose bits are all ones is aged back to all zeros. Because stores write through, an eviction only clears valid bits and never writes data back.

Requests use a valid/ready handshake, and so do results. A request is taken when `req_valid` and `req_ready` are both high. `req_ready` is high whenever no result is waiting, or when the waiting result is taken in the same cycle. A result stays stable until `res_ready` accepts it. The NRU access port and the NRU read port are plain control pins.

Top module: `chunk_allocator`

## Requirements
- R1: A request accepted at a clock edge produces its result from that same edge. `req_ready` is low while a result is held with `res_ready` low, and the held result does not change.
- R2: The number of slots filled equals the number of set bits in the missing-chunk mask (1 to 4). Slot index s = 4*group + position. Fill bit s marks slot s. Missing chunks, in ascending chunk order, get the filled slots in ascending slot order, and `res_slot[4c+3:4c]` is the slot of chunk c.
- R3: Invalid slots in a group that has a valid chunk and a shared tag equal to the request's are used first, lowest index first.
- R4: After those, slots of groups with no valid chunk are used, lowest index first. Each such group is flagged in `res_retag` to take the request's shared tag. At most one group is flagged per result.
- R5: An invalid slot in a group that holds a valid chunk under a different shared tag is never filled, unless that whole group is cleared as described in R7.
- R6: If free slots fall short and a group matches the shared tag, the shortfall is made up by evicting valid slots of matching groups. Slots with NRU bit 0 are taken first, and slots with NRU bit 1 only when too few have bit 0.
- R7: If no slot is free and no group matches, one whole group is cleared. The chosen group holds an NRU-0 valid slot whenever one exists. All of its valid slots are invalidated, its lowest slots are filled, and it is flagged for retag.
- R8: Ties among equally eligible victims start from a rotating point drawn from a 16-bit LFSR with a nonzero seed, which advances on every accepted request. Repeated identical requests therefore do not always pick the same victim.
- R9: An access sets the NRU bits of the slots in `acc_mask` for `acc_set`. If this makes all sixteen bits of the set one, the set's bits become all zero instead. The new value can be read from `nru_rd_bits` after the edge.
- R10: After reset, no result is pending and every NRU bit of every set is zero.
- R11: Only slots that were valid are invalidated. No slot that stays valid is filled. All invalidations of a request are reported together in one result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Allocation request valid |
| req_ready | output | 1 | Request can be accepted |
| req_set | input | SET_W | Set index of the request |
| req_stag | input | STAG_W | Shared tag of the line |
| req_ptag | input | PTAG_W | Private tag of the line |
| req_miss | input | 4 | Missing-chunk mask |
| req_vbits | input | 16 | Valid bit of every slot in the set |
| req_grp_stag | input | 4*STAG_W | Shared tags of groups 0..3, group g at [g*STAG_W +: STAG_W] |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result accepted |
| res_fill | output | 16 | Slots that receive a chunk |
| res_inval | output | 16 | Valid slots to invalidate |
| res_retag | output | 4 | Groups that take the new shared tag |
| res_slot | output | 16 | Slot of each missing chunk, 4 bits per chunk |
| res_miss | output | 4 | Missing-chunk mask of the result |
| res_stag | output | STAG_W | Shared tag of the result |
| res_ptag | output | PTAG_W | Private tag of the result |
| acc_valid | input | 1 | NRU access update valid |
| acc_set | input | SET_W | Set of the access |
| acc_mask | input | 16 | Slots accessed |
| nru_rd_set | input | SET_W | Set whose NRU bits are read |
| nru_rd_bits | output | 16 | NRU bits of `nru_rd_set` |

## Verification
A result is due exactly one clock edge after the edge that accepts its request. The bench drives inputs two time units after a rising edge and samples only on falling edges. It pops an expected entry from its queue at each falling edge where `res_valid` and `res_ready` are both high. An NRU update is due on `nru_rd_bits` right after the edge that samples `acc_valid`, so reads happen on the falling edge that follows. For back-pressure, the held result is compared over three falling edges, and a second request is kept waiting until `res_ready` rises.

// File: rtl/chunk_alloc_pkg.sv
package chunk_alloc_pkg;
  localparam int GROUPS      = 4;
  localparam int GROUP_SLOTS = 4;
  localparam int SLOTS       = GROUPS * GROUP_SLOTS;
  localparam int LINE_CHUNKS = GROUP_SLOTS;
  localparam int SLOT_W      = $clog2(SLOTS);
  localparam int OFF_W       = $clog2(GROUP_SLOTS);
  localparam int RND_W       = 16;
  localparam logic [RND_W-1:0] RND_SEED = 16'hACE1;

  typedef logic [SLOTS-1:0]  slot_mask_t;
  typedef logic [GROUPS-1:0] grp_mask_t;
endpackage

// File: rtl/ca_lfsr.sv
module ca_lfsr
  import chunk_alloc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  output logic [SLOT_W-1:0] start
);
  logic [RND_W-1:0] state;
  logic             fb;

  assign fb = state[15] ^ state[13] ^ state[12] ^ state[10];

  always_ff @(posedge clk) begin
    if (!rst_n)    state <= RND_SEED;
    else if (step) state <= {state[RND_W-2:0], fb};
  end

  // fold every nibble so that the whole register feeds the start point
  always_comb begin
    start = '0;
    for (int i = 0; i < RND_W / SLOT_W; i++) start ^= state[i*SLOT_W +: SLOT_W];
  end

  assert_lfsr_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);
endmodule

// File: rtl/ca_nru_store.sv
module ca_nru_store
  import chunk_alloc_pkg::*;
#(
  parameter int SETS = 32,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic [SET_W-1:0] acc_set,
  input  slot_mask_t       acc_mask,
  input  logic [SET_W-1:0] rd_a_set,
  output slot_mask_t       rd_a_bits,
  input  logic [SET_W-1:0] rd_b_set,
  output slot_mask_t       rd_b_bits
);
  slot_mask_t mem [SETS];
  slot_mask_t merged;

  assign merged    = mem[acc_set] | acc_mask;
  assign rd_a_bits = mem[rd_a_set];
  assign rd_b_bits = mem[rd_b_set];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SETS; i++) mem[i] <= '0;
    end else if (acc_valid) begin
      mem[acc_set] <= (&merged) ? '0 : merged;
    end
  end

  assert_nru_age_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && (&(mem[acc_set] | acc_mask))) |=> (mem[$past(acc_set)] == '0));

  assert_nru_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !(&(mem[acc_set] | acc_mask)))
      |=> ((mem[$past(acc_set)] & $past(acc_mask)) == $past(acc_mask)));
endmodule

// File: rtl/ca_slot_picker.sv
module ca_slot_picker
  import chunk_alloc_pkg::*;
#(
  parameter int STAG_W = 8
) (
  input  slot_mask_t                            valid_bits,
  input  logic [GROUPS-1:0][STAG_W-1:0]         grp_stag,
  input  logic [STAG_W-1:0]                     req_stag,
  input  logic [LINE_CHUNKS-1:0]                miss,
  input  slot_mask_t                            nru,
  input  logic [SLOT_W-1:0]                     start,
  output slot_mask_t                            fill,
  output slot_mask_t                            inval,
  output grp_mask_t                             retag,
  output logic [LINE_CHUNKS-1:0][SLOT_W-1:0]    slot_of
);
  grp_mask_t  busy, hit;
  slot_mask_t tier1, tier2, hit_live;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    assign busy[g] = |valid_bits[g*GROUP_SLOTS +: GROUP_SLOTS];
    assign hit[g]  = busy[g] && (grp_stag[g] == req_stag);
    for (genvar j = 0; j < GROUP_SLOTS; j++) begin : g_slot
      localparam int S = g * GROUP_SLOTS + j;
      assign tier1[S]    = hit[g] & ~valid_bits[S];
      assign tier2[S]    = ~busy[g];
      assign hit_live[S] = hit[g] & valid_bits[S];
    end
  end

  logic [SLOT_W-1:0] s, si, vslot;
  logic              found;

  always_comb begin
    int need, got;
    fill  = '0;
    inval = '0;
    retag = '0;
    s     = '0;
    si    = '0;
    vslot = '0;
    found = 1'b0;
    need  = $countones(miss);
    got   = 0;
    // free slots in a group already holding the tag
    for (int i = 0; i < SLOTS; i++) begin
      if (tier1[i] && got < need) begin fill[i] = 1'b1; got++; end
    end
    // slots in empty groups; the group adopts the request tag
    for (int i = 0; i < SLOTS; i++) begin
      si = SLOT_W'(i);
      if (tier2[i] && got < need) begin
        fill[i] = 1'b1;
        retag[si[SLOT_W-1:OFF_W]] = 1'b1;
        got++;
      end
    end
    if (got < need && |hit) begin
      // single-slot victims inside matching groups, NRU 0 before NRU 1
      for (int p = 0; p < 2; p++) begin
        for (int i = 0; i < SLOTS; i++) begin
          s = start + SLOT_W'(i);
          if (hit_live[s] && nru[s] == p[0] && got < need) begin
            fill[s]  = 1'b1;
            inval[s] = 1'b1;
            got++;
          end
        end
      end
    end else if (got == 0 && need != 0) begin
      // whole-group clear: the group of the first NRU-preferred live slot
      for (int p = 0; p < 2; p++) begin
        for (int i = 0; i < SLOTS; i++) begin
          s = start + SLOT_W'(i);
          if (valid_bits[s] && nru[s] == p[0] && !found) begin
            found = 1'b1;
            vslot = s;
          end
        end
      end
      if (found) begin
        retag[vslot[SLOT_W-1:OFF_W]] = 1'b1;
        for (int j = 0; j < GROUP_SLOTS; j++) begin
          inval[{vslot[SLOT_W-1:OFF_W], OFF_W'(j)}] = valid_bits[{vslot[SLOT_W-1:OFF_W], OFF_W'(j)}];
          if (j < need) fill[{vslot[SLOT_W-1:OFF_W], OFF_W'(j)}] = 1'b1;
        end
      end
    end
  end

  // pair missing chunks with filled slots, both ascending
  always_comb begin
    int rank, seen;
    rank    = 0;
    seen    = 0;
    slot_of = '0;
    for (int c = 0; c < LINE_CHUNKS; c++) begin
      if (miss[c]) begin
        seen = 0;
        for (int k = 0; k < SLOTS; k++) begin
          if (fill[k]) begin
            if (seen == rank) slot_of[c] = SLOT_W'(k);
            seen++;
          end
        end
        rank++;
      end
    end
  end
endmodule

// File: rtl/chunk_allocator.sv
module chunk_allocator
  import chunk_alloc_pkg::*;
#(
  parameter int SETS   = 32,
  parameter int STAG_W = 8,
  parameter int PTAG_W = 4,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [SET_W-1:0]              req_set,
  input  logic [STAG_W-1:0]             req_stag,
  input  logic [PTAG_W-1:0]             req_ptag,
  input  logic [LINE_CHUNKS-1:0]        req_miss,
  input  logic [SLOTS-1:0]              req_vbits,
  input  logic [GROUPS*STAG_W-1:0]      req_grp_stag,
  output logic                          res_valid,
  input  logic                          res_ready,
  output logic [SLOTS-1:0]              res_fill,
  output logic [SLOTS-1:0]              res_inval,
  output logic [GROUPS-1:0]             res_retag,
  output logic [LINE_CHUNKS*SLOT_W-1:0] res_slot,
  output logic [LINE_CHUNKS-1:0]        res_miss,
  output logic [STAG_W-1:0]             res_stag,
  output logic [PTAG_W-1:0]             res_ptag,
  input  logic                          acc_valid,
  input  logic [SET_W-1:0]              acc_set,
  input  logic [SLOTS-1:0]              acc_mask,
  input  logic [SET_W-1:0]              nru_rd_set,
  output logic [SLOTS-1:0]              nru_rd_bits
);
  logic                               take;
  logic [SLOT_W-1:0]                  start;
  slot_mask_t                         set_nru, pick_fill, pick_inval;
  grp_mask_t                          pick_retag;
  logic [LINE_CHUNKS-1:0][SLOT_W-1:0] pick_slot;

  assign req_ready = !res_valid || res_ready;
  assign take      = req_valid && req_ready;

  ca_lfsr u_rnd (.clk(clk), .rst_n(rst_n), .step(take), .start(start));

  ca_nru_store #(.SETS(SETS)) u_nru (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_set(acc_set), .acc_mask(acc_mask),
    .rd_a_set(req_set), .rd_a_bits(set_nru),
    .rd_b_set(nru_rd_set), .rd_b_bits(nru_rd_bits)
  );

  ca_slot_picker #(.STAG_W(STAG_W)) u_pick (
    .valid_bits(req_vbits), .grp_stag(req_grp_stag), .req_stag(req_stag),
    .miss(req_miss), .nru(set_nru), .start(start),
    .fill(pick_fill), .inval(pick_inval), .retag(pick_retag), .slot_of(pick_slot)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_fill  <= '0;
      res_inval <= '0;
      res_retag <= '0;
      res_slot  <= '0;
      res_miss  <= '0;
      res_stag  <= '0;
      res_ptag  <= '0;
    end else if (take) begin
      res_valid <= 1'b1;
      res_fill  <= pick_fill;
      res_inval <= pick_inval;
      res_retag <= pick_retag;
      res_slot  <= pick_slot;
      res_miss  <= req_miss;
      res_stag  <= req_stag;
      res_ptag  <= req_ptag;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_fill) && $stable(res_inval)
                                   && $stable(res_slot) && $stable(res_retag)));

  assert_fill_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ($countones(res_fill) == $countones(res_miss)));

  assert_one_retag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $onehot0(res_retag));

  assert_inval_live_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ((pick_inval & ~req_vbits) == '0));

  assert_no_overwrite_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ((pick_fill & req_vbits & ~pick_inval) == '0));
endmodule

// File: tb/chunk_allocator_test.sv
module chunk_allocator_test;
  import chunk_alloc_pkg::*;

  localparam int SETS = 32, STAG_W = 8, PTAG_W = 4, SET_W = $clog2(SETS);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, res_ready = 1'b1, acc_valid = 1'b0;
  logic req_ready, res_valid;
  logic [SET_W-1:0] req_set = '0, acc_set = '0, nru_rd_set = '0;
  logic [STAG_W-1:0] req_stag = '0, res_stag;
  logic [PTAG_W-1:0] req_ptag = '0, res_ptag;
  logic [3:0] req_miss = '0, res_miss, res_retag;
  logic [15:0] req_vbits = '0, res_fill, res_inval, res_slot, acc_mask = '0, nru_rd_bits;
  logic [31:0] req_grp_stag = '0;

  always #4 clk = ~clk;

  chunk_allocator #(.SETS(SETS), .STAG_W(STAG_W), .PTAG_W(PTAG_W)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_set(req_set), .req_stag(req_stag), .req_ptag(req_ptag), .req_miss(req_miss),
    .req_vbits(req_vbits), .req_grp_stag(req_grp_stag), .res_valid(res_valid),
    .res_ready(res_ready), .res_fill(res_fill), .res_inval(res_inval),
    .res_retag(res_retag), .res_slot(res_slot), .res_miss(res_miss),
    .res_stag(res_stag), .res_ptag(res_ptag), .acc_valid(acc_valid),
    .acc_set(acc_set), .acc_mask(acc_mask), .nru_rd_set(nru_rd_set),
    .nru_rd_bits(nru_rd_bits)
  );

  typedef struct {
    string       rq;
    logic [15:0] vb, fill, care, inval, slots;
    logic [3:0]  retag, miss;
    bit          chk_slots, whole;
  } exp_t;

  exp_t q[$];
  int   checks = 0, errors = 0;
  bit   grp_seen [4];

  task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic exp_t mk(string rq, logic [15:0] vb, logic [3:0] miss,
                              logic [15:0] fill, logic [15:0] care, logic [15:0] inval,
                              logic [3:0] retag, logic [15:0] slots, bit cs, bit wh);
    exp_t e;
    e.rq = rq; e.vb = vb; e.miss = miss; e.fill = fill; e.care = care; e.inval = inval;
    e.retag = retag; e.slots = slots; e.chk_slots = cs; e.whole = wh;
    return e;
  endfunction

  task automatic send(int set, logic [7:0] stag, logic [3:0] miss, logic [15:0] vb,
                      logic [31:0] gst, exp_t e);
    q.push_back(e);
    @(posedge clk); #2;
    req_valid = 1'b1; req_set = SET_W'(set); req_stag = stag; req_ptag = 4'h5;
    req_miss = miss; req_vbits = vb; req_grp_stag = gst;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #2;
    req_valid = 1'b0;
  endtask

  task automatic access(int set, logic [15:0] mask);
    @(posedge clk); #2;
    acc_valid = 1'b1; acc_set = SET_W'(set); acc_mask = mask;
    @(posedge clk); #2;
    acc_valid = 1'b0;
  endtask

  task automatic peek(int set, logic [15:0] exp, string rq);
    nru_rd_set = SET_W'(set);
    @(negedge clk);
    chk(rq, "nru bits", 32'(nru_rd_bits), 32'(exp));
  endtask

  // monitor: one transfer per falling edge with valid and ready
  always @(negedge clk) begin
    if (rst_n && res_valid && res_ready) begin
      if (q.size() == 0) chk("R1", "unexpected result", 1, 0);
      else begin
        exp_t e;
        int   g;
        e = q.pop_front();
        chk("R2", "fill count", $countones(res_fill), $countones(e.miss));
        chk("R11", "live slot overwritten", 32'(res_fill & e.vb & ~res_inval), 0);
        chk("R11", "invalid slot evicted", 32'(res_inval & ~e.vb), 0);
        if (e.whole) begin
          g = -1;
          for (int k = 0; k < 4; k++) if (res_inval == (16'hF << (4*k))) g = k;
          chk("R7", "whole group cleared", (g >= 0) ? 1 : 0, 1);
          if (g >= 0) begin
            chk("R7", "group fill", 32'(res_fill),
                32'(((16'h1 << $countones(e.miss)) - 16'h1) << (4*g)));
            chk("R7", "group retag", 32'(res_retag), 32'(4'h1 << g));
            grp_seen[g] = 1'b1;
          end
        end else begin
          chk(e.rq, "fill", 32'(res_fill & e.care), 32'(e.fill & e.care));
          chk(e.rq, "inval", 32'(res_inval & e.care), 32'(e.inval & e.care));
          chk(e.rq, "retag", 32'(res_retag), 32'(e.retag));
          if (e.chk_slots) chk("R2", "chunk slots", 32'(res_slot), 32'(e.slots));
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] held;
    int          distinct;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "res_valid after reset", 32'(res_valid), 0);
    chk("R1", "req_ready after reset", 32'(req_ready), 1);
    peek(0, 16'h0000, "R10");
    peek(31, 16'h0000, "R10");

    // R4: empty set, four chunks land in group 0
    send(0, 8'h33, 4'hF, 16'h0000, 32'h0,
         mk("R4", 16'h0000, 4'hF, 16'h000F, 16'hFFFF, 16'h0, 4'h1, 16'h3210, 1, 0));
    // R3: matching group with two free slots
    send(1, 8'h12, 4'b0101, 16'h0003, 32'h0000_0012,
         mk("R3", 16'h0003, 4'b0101, 16'h000C, 16'hFFFF, 16'h0, 4'h0, 16'h0302, 1, 0));
    // R3 R4 R5: one matching slot, foreign group with holes skipped, empty group used
    send(2, 8'h12, 4'b1011, 16'hF017, 32'h7700_9912,
         mk("R3 R4 R5", 16'hF017, 4'b1011, 16'h0308, 16'hFFFF, 16'h0, 4'h4, 16'h9083, 1, 0));
    // R6: matching full group, NRU-0 slots 6 and 7 evicted
    access(3, 16'h0030);
    peek(3, 16'h0030, "R9");
    send(3, 8'h21, 4'b0011, 16'hFFFF, 32'h4030_2110,
         mk("R6", 16'hFFFF, 4'b0011, 16'h00C0, 16'hFFFF, 16'h00C0, 4'h0, 16'h0076, 1, 0));
    // R6: three needed, two NRU-0 plus one NRU-1 from slots 4/5
    send(3, 8'h21, 4'b0111, 16'hFFFF, 32'h4030_2110,
         mk("R6", 16'hFFFF, 4'b0111, 16'h00C0, 16'hFFCF, 16'h00C0, 4'h0, 16'h0, 0, 0));
    // R7: no match, only slot 13 has NRU 0 -> group 3 cleared
    access(7, 16'hDFFF);
    peek(7, 16'hDFFF, "R9");
    send(7, 8'h55, 4'b1001, 16'hFFFF, 32'h0403_0201,
         mk("R7", 16'hFFFF, 4'b1001, 16'h3000, 16'hFFFF, 16'hF000, 4'h8, 16'hD00C, 1, 0));
    // R9: completing the set ages it to zero
    access(7, 16'h2000);
    peek(7, 16'h0000, "R9");

    // R1: back-pressure holds the result and stalls the next request
    while (q.size() != 0) @(negedge clk);
    @(posedge clk); #2 res_ready = 1'b0;
    fork
      begin
        send(1, 8'h12, 4'b0101, 16'h0003, 32'h0000_0012,
             mk("R1", 16'h0003, 4'b0101, 16'h000C, 16'hFFFF, 16'h0, 4'h0, 16'h0302, 1, 0));
        send(1, 8'h12, 4'b0101, 16'h0003, 32'h0000_0012,
             mk("R1", 16'h0003, 4'b0101, 16'h000C, 16'hFFFF, 16'h0, 4'h0, 16'h0302, 1, 0));
      end
      begin
        do @(negedge clk); while (!res_valid);
        held = res_fill;
        repeat (3) @(negedge clk);
        chk("R1", "held fill", 32'(res_fill), 32'(held));
        chk("R1", "held valid", 32'(res_valid), 1);
        chk("R1", "ready low under stall", 32'(req_ready), 0);
        @(posedge clk); #2 res_ready = 1'b1;
      end
    join

    // R8: identical whole-group requests with all NRU bits zero
    for (int n = 0; n < 8; n++)
      send(9, 8'hEE, 4'b0001, 16'hFFFF, 32'h0403_0201,
           mk("R7", 16'hFFFF, 4'b0001, 16'h0, 16'h0, 16'h0, 4'h0, 16'h0, 0, 1));
    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    distinct = 0;
    for (int k = 0; k < 4; k++) if (grp_seen[k]) distinct++;
    chk("R8", "victim groups vary", (distinct > 1) ? 1 : 0, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule